// File: doc/BRIEF.md
# Fixed-Latency Capture Stage with Event Derandomizer

This block is the first capture stage of a detector front-end. On every crossing clock it takes one sample set of channel words and delays it through a ring of fixed length. The trigger decision for a crossing comes back a fixed number of cycles later. When that decision is an accept, the delayed sample set is copied, together with identifying tags, into a small FIFO that holds whole events.

A serializer drains the FIFO one 16-bit word per clock. Each frame carries the channel words followed by four tag words: the crossing number, the accept number split into two halves, and an XOR check word. Only one word leaves per cycle, so the frame length sets the highest sustainable accept rate. The FIFO absorbs bursts of accepts that arrive closer together than that.

When an accept arrives while the FIFO is full, that event is dropped and a sticky error flag is raised. The events already stored are not touched.

Top module: `fe_capture`

## Requirements
- R1: The crossing tag of an event is the value the 12-bit crossing counter held when its sample set was presented. The counter is 0 after reset, advances by one per clock, and goes from BC_MAX back to 0.
- R2: When `bx_clear` is high at a clock edge, the sample set of that edge keeps the counter's current value, and the sample set of the next edge is tagged 0.
- R3: An accept sampled at clock edge m selects the sample set that was presented at edge m-LAT.
- R4: A frame is NCH channel words, channel 0 first (bits 15:0 of `ch_data`), followed by four tag words in this order:
  - T0 = {4'b0, crossing tag}
  - T1 = event number bits 31:16
  - T2 = event number bits 15:0
  - T3 = XOR of the NCH channel words
- R5: The event number is a 32-bit count that is 0 after reset. Every accept, including a dropped one, is given the current count and then advances it by one.
- R6: `out_valid` is high on every word of a frame, and `out_last` is high only on word NCH+4. A frame's first word appears in the cycle after its accept edge, or straight after the previous frame's last word. Stored frames follow one another with no idle cycle.
- R7: `occupancy` counts the events held. It rises at the edge that stores an event and falls at the edge that sends that event's last word.
- R8: An accept seen while `occupancy` equals DEPTH stores nothing: occupancy does not rise, and the stored events still come out intact.
- R9: A dropped accept sets `overflow` at that edge. Once set, `overflow` stays high until reset.
- R10: Reset clears `out_valid`, `out_last`, `occupancy` and `overflow`, and restarts both counters at 0.
- R11: Events leave in the order in which they were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crossing clock |
| rst | input | 1 | Synchronous reset, active high |
| ch_data | input | NCH*16 | One sample set; channel k in bits 16k+15:16k |
| accept | input | 1 | Trigger accept for the crossing LAT cycles back |
| bx_clear | input | 1 | Synchronous clear of the crossing counter |
| out_data | output | 16 | Frame word |
| out_valid | output | 1 | Frame word is valid |
| out_last | output | 1 | Last word of a frame |
| occupancy | output | clog2(DEPTH+1) | Events held in the FIFO |
| overflow | output | 1 | Sticky flag: an accept was dropped |

## Verification
The bench builds the block with NCH=4, LAT=10, DEPTH=4 and BC_MAX=19. These values give an 8-word frame and a four-event FIFO, so a burst of six back-to-back accepts reaches the full condition and the drop path within a few cycles. The crossing counter wraps every 20 cycles, so many wraps fall inside tagged events, and clear pulses placed just over LAT cycles before an accept land their effect inside a selected sample. A second reset in the middle of the run shows that the sticky flag and both counters restart.

// File: rtl/fe_capture_pkg.sv
package fe_capture_pkg;

    localparam int WORD_W = 16;
    localparam int BX_W   = 12;
    localparam int EVT_W  = 32;
    localparam int N_TAG  = 4;

    typedef logic [WORD_W-1:0] word_t;
    typedef logic [BX_W-1:0]   bx_t;
    typedef logic [EVT_W-1:0]  evt_t;

    // Identification carried with every stored event
    typedef struct packed {
        bx_t   bx;
        evt_t  evt;
        word_t chk;
    } ev_tag_t;

    // Position of a tag word after the channel words (order is fixed by R4)
    typedef enum logic [1:0] {
        TAG_BX     = 2'd0,
        TAG_EVT_HI = 2'd1,
        TAG_EVT_LO = 2'd2,
        TAG_CHK    = 2'd3
    } tag_sel_e;

    function automatic word_t tag_word(input ev_tag_t t, input tag_sel_e s);
        case (s)
            TAG_BX:     return {{(WORD_W-BX_W){1'b0}}, t.bx};
            TAG_EVT_HI: return t.evt[EVT_W-1:WORD_W];
            TAG_EVT_LO: return t.evt[WORD_W-1:0];
            default:    return t.chk;
        endcase
    endfunction

    function automatic bx_t bx_next(input bx_t cur, input bx_t top, input logic clr);
        if (clr)             return '0;
        else if (cur == top) return '0;
        else                 return cur + bx_t'(1);
    endfunction

endpackage

// File: rtl/fe_bx_counter.sv
module fe_bx_counter
    import fe_capture_pkg::*;
#(
    parameter int BC_MAX = 3563
) (
    input  logic clk,
    input  logic rst,
    input  logic clr,
    output bx_t  bx_o
);
    localparam bx_t TOP = bx_t'(BC_MAX);

    always_ff @(posedge clk) begin
        if (rst) bx_o <= '0;
        else     bx_o <= bx_next(bx_o, TOP, clr);
    end

    a_r1_bx_range: assert property (@(posedge clk) disable iff (rst)
        bx_o <= TOP);

    a_r2_bx_clear: assert property (@(posedge clk) disable iff (rst)
        clr |=> (bx_o == '0));

    a_r1_bx_step: assert property (@(posedge clk) disable iff (rst)
        (!clr && bx_o != TOP) |=> (bx_o == $past(bx_o) + bx_t'(1)));

endmodule

// File: rtl/fe_latency_pipe.sv
module fe_latency_pipe
    import fe_capture_pkg::*;
#(
    parameter int NCH = 32,
    parameter int LAT = 160
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NCH*WORD_W-1:0] din,
    input  bx_t                   bx_in,
    output logic [NCH*WORD_W-1:0] dout,
    output bx_t                   bx_out
);
    localparam int DATA_W = NCH*WORD_W;
    localparam int ENT_W  = DATA_W + BX_W;
    localparam int PW     = (LAT > 1) ? $clog2(LAT) : 1;
    localparam logic [PW-1:0] LAST_P = PW'(LAT-1);

    logic [ENT_W-1:0] ring [LAT];
    logic [PW-1:0]    ptr;
    logic [ENT_W-1:0] oldest;

    // The slot about to be overwritten holds the entry from LAT edges ago
    assign oldest = ring[ptr];
    assign dout   = oldest[DATA_W-1:0];
    assign bx_out = oldest[ENT_W-1:DATA_W];

    always_ff @(posedge clk) begin
        if (!rst) ring[ptr] <= {bx_in, din};
    end

    always_ff @(posedge clk) begin
        if (rst)                ptr <= '0;
        else if (ptr == LAST_P) ptr <= '0;
        else                    ptr <= ptr + PW'(1);
    end

    a_r3_ptr_range: assert property (@(posedge clk) disable iff (rst)
        ptr <= LAST_P);

endmodule

// File: rtl/fe_derand_fifo.sv
module fe_derand_fifo
    import fe_capture_pkg::*;
#(
    parameter int NCH   = 32,
    parameter int DEPTH = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          acc,
    input  logic [NCH*WORD_W-1:0]         ch_in,
    input  ev_tag_t                       tag_in,
    input  logic                          pop,
    output logic [NCH*WORD_W-1:0]         head_ch,
    output ev_tag_t                       head_tag,
    output logic                          empty,
    output logic [$clog2(DEPTH+1)-1:0]    count,
    output logic                          ovf
);
    localparam int DATA_W = NCH*WORD_W;
    localparam int TAG_W  = $bits(ev_tag_t);
    localparam int ENT_W  = DATA_W + TAG_W;
    localparam int AW     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW     = $clog2(DEPTH+1);
    localparam logic [AW-1:0] LAST_A = AW'(DEPTH-1);
    localparam logic [CW-1:0] FULL_C = CW'(DEPTH);

    logic [ENT_W-1:0] slots [DEPTH];
    logic [AW-1:0]    wp, rp;
    logic             full, push;
    logic [ENT_W-1:0] head;

    assign full  = (count == FULL_C);
    assign empty = (count == '0);
    assign push  = acc && !full;

    assign head     = slots[rp];
    assign head_ch  = head[DATA_W-1:0];
    assign head_tag = ev_tag_t'(head[ENT_W-1:DATA_W]);

    always_ff @(posedge clk) begin
        if (push) slots[wp] <= {tag_in, ch_in};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
            ovf   <= 1'b0;
        end else begin
            if (push) wp <= (wp == LAST_A) ? '0 : wp + AW'(1);
            if (pop)  rp <= (rp == LAST_A) ? '0 : rp + AW'(1);
            count <= count + CW'(push) - CW'(pop);
            if (acc && full) ovf <= 1'b1;
        end
    end

    a_r7_count_bound: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_C);

    a_r7_pop_nonempty: assert property (@(posedge clk) disable iff (rst)
        pop |-> !empty);

    a_r8_drop_no_store: assert property (@(posedge clk) disable iff (rst)
        (acc && full && !pop) |=> (count == $past(count)));

    a_r9_ovf_set: assert property (@(posedge clk) disable iff (rst)
        (acc && full) |=> ovf);

    a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
        ovf |=> ovf);

endmodule

// File: rtl/fe_frame_tx.sv
module fe_frame_tx
    import fe_capture_pkg::*;
#(
    parameter int NCH = 32
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  empty,
    input  logic [NCH*WORD_W-1:0] head_ch,
    input  ev_tag_t               head_tag,
    output logic                  pop,
    output word_t                 out_data,
    output logic                  out_valid,
    output logic                  out_last
);
    localparam int FRAME_LEN = NCH + N_TAG;
    localparam int IW        = $clog2(FRAME_LEN);
    localparam logic [IW-1:0] LAST_I = IW'(FRAME_LEN-1);

    logic [IW-1:0] idx;
    word_t         frame_w [FRAME_LEN];

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        assign frame_w[g] = head_ch[g*WORD_W +: WORD_W];
    end
    for (genvar t = 0; t < N_TAG; t++) begin : g_tag
        assign frame_w[NCH+t] = tag_word(head_tag, tag_sel_e'(t));
    end

    assign pop = !empty && (idx == LAST_I);

    always_ff @(posedge clk) begin
        if (rst) begin
            idx       <= '0;
            out_data  <= '0;
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end else if (!empty) begin
            out_data  <= frame_w[idx];
            out_valid <= 1'b1;
            out_last  <= (idx == LAST_I);
            idx       <= (idx == LAST_I) ? '0 : idx + IW'(1);
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end

    a_r6_last_in_valid: assert property (@(posedge clk) disable iff (rst)
        out_last |-> out_valid);

    a_r6_no_gap: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |-> (idx != '0 && !empty));

    a_r6_frame_continues: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_last) |=> out_valid);

endmodule

// File: rtl/fe_capture.sv
module fe_capture
    import fe_capture_pkg::*;
#(
    parameter int NCH    = 32,
    parameter int LAT    = 160,
    parameter int DEPTH  = 16,
    parameter int BC_MAX = 3563
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic [NCH*16-1:0]              ch_data,
    input  logic                           accept,
    input  logic                           bx_clear,
    output logic [15:0]                    out_data,
    output logic                           out_valid,
    output logic                           out_last,
    output logic [$clog2(DEPTH+1)-1:0]     occupancy,
    output logic                           overflow
);
    localparam int DATA_W = NCH*WORD_W;

    bx_t                bx_now, bx_dly;
    logic [DATA_W-1:0]  ch_dly, head_ch;
    evt_t               evt_cnt;
    word_t              chk;
    ev_tag_t            tag_new, head_tag;
    logic               fifo_empty, pop;

    fe_bx_counter #(.BC_MAX(BC_MAX)) u_bx (
        .clk  (clk),
        .rst  (rst),
        .clr  (bx_clear),
        .bx_o (bx_now)
    );

    fe_latency_pipe #(.NCH(NCH), .LAT(LAT)) u_pipe (
        .clk    (clk),
        .rst    (rst),
        .din    (ch_data),
        .bx_in  (bx_now),
        .dout   (ch_dly),
        .bx_out (bx_dly)
    );

    always_comb begin
        chk = '0;
        for (int j = 0; j < NCH; j++) chk ^= ch_dly[j*WORD_W +: WORD_W];
    end

    assign tag_new = '{bx: bx_dly, evt: evt_cnt, chk: chk};

    // Every accept takes a number, stored or not
    always_ff @(posedge clk) begin
        if (rst)         evt_cnt <= '0;
        else if (accept) evt_cnt <= evt_cnt + evt_t'(1);
    end

    fe_derand_fifo #(.NCH(NCH), .DEPTH(DEPTH)) u_fifo (
        .clk      (clk),
        .rst      (rst),
        .acc      (accept),
        .ch_in    (ch_dly),
        .tag_in   (tag_new),
        .pop      (pop),
        .head_ch  (head_ch),
        .head_tag (head_tag),
        .empty    (fifo_empty),
        .count    (occupancy),
        .ovf      (overflow)
    );

    fe_frame_tx #(.NCH(NCH)) u_tx (
        .clk       (clk),
        .rst       (rst),
        .empty     (fifo_empty),
        .head_ch   (head_ch),
        .head_tag  (head_tag),
        .pop       (pop),
        .out_data  (out_data),
        .out_valid (out_valid),
        .out_last  (out_last)
    );

    a_r5_evt_advance: assert property (@(posedge clk) disable iff (rst)
        accept |=> (evt_cnt == $past(evt_cnt) + evt_t'(1)));

    a_r5_evt_hold: assert property (@(posedge clk) disable iff (rst)
        !accept |=> $stable(evt_cnt));

endmodule

// File: tb/test_fe_capture.sv
module test_fe_capture;
    import fe_capture_pkg::*;

    localparam int NCH    = 4;
    localparam int LAT    = 10;
    localparam int DEPTH  = 4;
    localparam int BC_MAX = 19;
    localparam int FRAME  = NCH + N_TAG;
    localparam int HW     = 64;

    logic                        clk = 1'b0;
    logic                        rst = 1'b1;
    logic [NCH*16-1:0]           ch_data = '0;
    logic                        accept = 1'b0;
    logic                        bx_clear = 1'b0;
    logic [15:0]                 out_data;
    logic                        out_valid, out_last;
    logic [$clog2(DEPTH+1)-1:0]  occupancy;
    logic                        overflow;

    fe_capture #(.NCH(NCH), .LAT(LAT), .DEPTH(DEPTH), .BC_MAX(BC_MAX)) i_fe_capture (
        .clk(clk), .rst(rst), .ch_data(ch_data), .accept(accept), .bx_clear(bx_clear),
        .out_data(out_data), .out_valid(out_valid), .out_last(out_last),
        .occupancy(occupancy), .overflow(overflow)
    );

    always #2 clk = ~clk;

    typedef struct packed {
        logic [15:0] w;
        logic        last;
        logic [2:0]  kind;   // 0 channel, 1 crossing, 2 evt hi, 3 evt lo, 4 check
    } exp_t;

    typedef struct packed {
        int gap;
        int burst;
        bit clr;
        bit ovf;
    } vec_t;

    localparam vec_t TBL [8] = '{
        '{20, 1, 1'b0, 1'b0},
        '{14, 2, 1'b1, 1'b0},
        '{40, 4, 1'b0, 1'b0},
        '{13, 1, 1'b1, 1'b0},
        '{50, 3, 1'b0, 1'b0},
        '{60, 6, 1'b0, 1'b1},
        '{ 8, 2, 1'b0, 1'b1},
        '{45, 1, 1'b1, 1'b1}
    };

    exp_t        q[$];
    int          n_chk = 0, n_fail = 0;
    int          e = 0, gseed = 1, bc_m = 0, occ_m = 0;
    logic [31:0] ev_m = '0;
    logic        ovf_m = 1'b0;
    int          hseed [HW];
    int          hbc   [HW];
    bit          done = 1'b0;

    function automatic logic [15:0] dword(input int s, input int j);
        return 16'((s*37 + j*4099 + 11) & 32'hFFFF);
    endfunction

    function automatic string kind_req(input logic [2:0] k);
        case (k)
            3'd0:    return "R3 R11";
            3'd1:    return "R1 R2";
            3'd2:    return "R5";
            3'd3:    return "R5";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, e);
        end
    endtask

    task automatic step(input logic a, input logic c);
        exp_t pend [FRAME];
        logic push;
        logic had;
        exp_t got;
        logic [15:0] w, ck;
        int src;
        hseed[e % HW] = gseed;
        hbc[e % HW]   = bc_m;
        for (int j = 0; j < NCH; j++) ch_data[j*16 +: 16] = dword(gseed, j);
        accept   = a;
        bx_clear = c;
        push = 1'b0;
        if (a) begin
            if (occ_m == DEPTH) begin
                ovf_m = 1'b1;
            end else begin
                push = 1'b1;
                src = (e - LAT) % HW;
                ck = '0;
                for (int j = 0; j < NCH; j++) begin
                    w = dword(hseed[src], j);
                    ck ^= w;
                    pend[j] = '{w: w, last: 1'b0, kind: 3'd0};
                end
                pend[NCH]   = '{w: 16'(hbc[src]), last: 1'b0, kind: 3'd1};
                pend[NCH+1] = '{w: ev_m[31:16],   last: 1'b0, kind: 3'd2};
                pend[NCH+2] = '{w: ev_m[15:0],    last: 1'b0, kind: 3'd3};
                pend[NCH+3] = '{w: ck,            last: 1'b1, kind: 3'd4};
            end
            ev_m = ev_m + 32'd1;
        end
        bc_m = c ? 0 : ((bc_m == BC_MAX) ? 0 : bc_m + 1);
        had = (q.size() > 0);
        @(posedge clk);
        @(negedge clk);
        accept   = 1'b0;
        bx_clear = 1'b0;
        e++;
        gseed++;
        check("R6 valid", 32'(out_valid), 32'(had));
        got = '0;
        if (had) begin
            got = q.pop_front();
            check(kind_req(got.kind), 32'(out_data), 32'(got.w));
            check("R6 last", 32'(out_last), 32'(got.last));
        end
        occ_m = occ_m + int'(push) - int'(had && got.last);
        check("R7 R8 occupancy", 32'(occupancy), 32'(occ_m));
        check("R9 overflow", 32'(overflow), 32'(ovf_m));
        if (push) for (int k = 0; k < FRAME; k++) q.push_back(pend[k]);
    endtask

    task automatic do_reset();
        rst    = 1'b1;
        accept = 1'b0;
        bx_clear = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        e = 0; bc_m = 0; occ_m = 0; ev_m = '0; ovf_m = 1'b0;
        q.delete();
        check("R10 valid", 32'(out_valid), 32'd0);
        check("R10 last", 32'(out_last), 32'd0);
        check("R10 occupancy", 32'(occupancy), 32'd0);
        check("R10 R9 overflow", 32'(overflow), 32'd0);
    endtask

    initial begin
        do_reset();
        // Table walk: idle gap (optional clear on its first cycle), then a burst of accepts
        for (int v = 0; v < 8; v++) begin
            for (int g = 0; g < TBL[v].gap; g++) step(1'b0, (g == 0) && TBL[v].clr);
            for (int b = 0; b < TBL[v].burst; b++) step(1'b1, 1'b0);
            check("R9 table overflow", 32'(overflow), 32'(TBL[v].ovf));
        end
        // Drain everything: R7 count returns to zero, R6 stream stops
        repeat (80) step(1'b0, 1'b0);
        check("R7 drained", 32'(occupancy), 32'd0);
        check("R6 idle", 32'(out_valid), 32'd0);
        // Second reset clears the sticky flag and restarts numbering (R9 R10 R5)
        do_reset();
        repeat (15) step(1'b0, 1'b0);
        step(1'b1, 1'b0);
        step(1'b1, 1'b0);
        repeat (25) step(1'b0, 1'b0);
        check("R5 restart drained", 32'(occupancy), 32'd0);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule